// File: doc/BRIEF.md
# Two-Group Scan-Enable Launch/Capture Sequencer

This block holds two scan chains of equal, parameterised length. It also holds the sequencer that applies one transition-fault test to them. Each test has three phases. First, a serial load shifts the first vector into every flop. Next comes a launch cycle, and after it a capture cycle. Every flop belongs to one of two enable groups. During launch and capture, a flop whose group enable is high takes the value of its predecessor in the chain, which is a skewed-load transition. A flop whose group enable is low takes its bit of the functional response, which is a broadside transition. One test can therefore mix both kinds of transition across the flops.

The two enables reach their launch levels in a single slow preparation cycle. They then hold those levels unchanged through launch and capture, so no enable has to switch at speed. After capture, the captured state is shifted out serially while the next pattern is shifted in. Then a one-cycle done pulse is given. The group map is a per-flop input. It is sampled only when a test starts from idle.

Top module: `launch_capture_ctrl`

## Requirements
- R1: After reset, both chains hold all zeros, both enables are 0, and busy and done are 0.
- R2: A start pulse while idle latches the group maps and raises both enables. The sequencer then performs exactly N shift cycles. In each cycle the scan input enters flop 0 and flop k feeds flop k+1, so the first bit shifted in ends in flop N-1.
- R3: After the load comes one preparation cycle in which both chains hold their contents. On its edge the enables take the requested launch levels (the group 1 level on sen1 and the group 2 level on sen2).
- R4: On the launch edge and again on the capture edge, flop k uses sen2 if its map bit is 1 and sen1 if its map bit is 0. If that enable is 1, the flop loads its predecessor (flop 0 loads the scan input). If that enable is 0, the flop loads response bit k.
- R5: The enable levels on the capture edge are the same as those on the launch edge.
- R6: After capture, both enables are 1 for N unload shift cycles. The scan output is the last flop of its chain, so captured bit N-1 is visible before the first unload edge. After the unload, the chains hold the newly shifted pattern.
- R7: After the unload, done is high for exactly one cycle with busy low. After that, both enables return to 0.
- R8: While a test is running, changes to the group maps, to the level inputs after the preparation cycle, and to start have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test (honoured only when idle) |
| grp_map_a | input | N | Group of each chain-A flop (1 = group 2) |
| grp_map_b | input | N | Group of each chain-B flop (1 = group 2) |
| lvl_sen1 | input | 1 | Group 1 enable level for launch and capture |
| lvl_sen2 | input | 1 | Group 2 enable level for launch and capture |
| scan_in_a | input | 1 | Serial input of chain A |
| scan_in_b | input | 1 | Serial input of chain B |
| resp_a | input | N | Functional response for chain A |
| resp_b | input | N | Functional response for chain B |
| scan_out_a | output | 1 | Serial output of chain A |
| scan_out_b | output | 1 | Serial output of chain B |
| chain_a | output | N | Parallel contents of chain A |
| chain_b | output | N | Parallel contents of chain B |
| sen1 | output | 1 | Group 1 scan enable |
| sen2 | output | 1 | Group 2 scan enable |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with a chain length of 5. That length is short enough that random group maps reach every mix of skewed-load and broadside flops, including the boundary flop 0, which takes the scan input as its predecessor. It is also long enough that the unload order and the run of shift cycles are visible. Directed tests cover an all-broadside setting, an all-skewed setting, and the mixed setting with group 1 low and group 2 high. Tests with disturbed inputs change the maps, the levels and start mid-test.

// File: rtl/launch_capture_ctrl.sv
module launch_capture_ctrl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] grp_map_a,
  input  logic [N-1:0] grp_map_b,
  input  logic         lvl_sen1,
  input  logic         lvl_sen2,
  input  logic         scan_in_a,
  input  logic         scan_in_b,
  input  logic [N-1:0] resp_a,
  input  logic [N-1:0] resp_b,
  output logic         scan_out_a,
  output logic         scan_out_b,
  output logic [N-1:0] chain_a,
  output logic [N-1:0] chain_b,
  output logic         sen1,
  output logic         sen2,
  output logic         busy,
  output logic         done
);
  localparam int CW = $clog2(N) + 1;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_PREP, S_LAUNCH, S_CAPT, S_UNLOAD, S_DONE} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [N-1:0]  map_a_q, map_b_q;
  logic [N-1:0]  upd_a, upd_b;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_bit
      logic en_a, en_b, pr_a, pr_b;
      assign en_a = map_a_q[k] ? sen2 : sen1;
      assign en_b = map_b_q[k] ? sen2 : sen1;
      if (k == 0) begin : g_head
        assign pr_a = scan_in_a;
        assign pr_b = scan_in_b;
      end else begin : g_body
        assign pr_a = chain_a[k-1];
        assign pr_b = chain_b[k-1];
      end
      assign upd_a[k] = en_a ? pr_a : resp_a[k];
      assign upd_b[k] = en_b ? pr_b : resp_b[k];
    end
  endgenerate

  assign scan_out_a = chain_a[N-1];
  assign scan_out_b = chain_b[N-1];
  assign done = (st == S_DONE);
  assign busy = (st != S_IDLE) && (st != S_DONE);

  wire last = (cnt == CW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      map_a_q <= '0;
      map_b_q <= '0;
      chain_a <= '0;
      chain_b <= '0;
      sen1    <= 1'b0;
      sen2    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_LOAD;
          cnt     <= '0;
          map_a_q <= grp_map_a;
          map_b_q <= grp_map_b;
          sen1    <= 1'b1;
          sen2    <= 1'b1;
        end
        S_LOAD, S_UNLOAD: begin
          chain_a <= {chain_a[N-2:0], scan_in_a};
          chain_b <= {chain_b[N-2:0], scan_in_b};
          cnt     <= cnt + 1'b1;
          if (last) st <= (st == S_LOAD) ? S_PREP : S_DONE;
        end
        S_PREP: begin
          sen1 <= lvl_sen1;
          sen2 <= lvl_sen2;
          st   <= S_LAUNCH;
        end
        S_LAUNCH: begin
          chain_a <= upd_a;
          chain_b <= upd_b;
          st      <= S_CAPT;
        end
        S_CAPT: begin
          chain_a <= upd_a;
          chain_b <= upd_b;
          sen1    <= 1'b1;
          sen2    <= 1'b1;
          cnt     <= '0;
          st      <= S_UNLOAD;
        end
        S_DONE: begin
          sen1 <= 1'b0;
          sen2 <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_load_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD) |-> (sen1 && sen2));

  p_prep_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PREP) |=> (chain_a == $past(chain_a) && chain_b == $past(chain_b)));

  p_static_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CAPT) |-> $stable({sen1, sen2}));

  p_unload_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UNLOAD) |-> (sen1 && sen2));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !sen1 && !sen2));

  p_map_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(map_a_q) && $stable(map_b_q)));
endmodule

// File: tb/launch_capture_ctrl_test.sv
module launch_capture_ctrl_test;
  localparam int N = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0] grp_map_a = '0, grp_map_b = '0, resp_a = '0, resp_b = '0;
  logic lvl_sen1 = 1'b0, lvl_sen2 = 1'b0, scan_in_a = 1'b0, scan_in_b = 1'b0;
  logic scan_out_a, scan_out_b, sen1, sen2, busy, done;
  logic [N-1:0] chain_a, chain_b;

  int checks = 0, fails = 0, cycles = 0;

  launch_capture_ctrl #(.N(N)) uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++; checks++;
      $display("FAIL watchdog: act=%0d exp<=50000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] step(input logic [N-1:0] cur, input logic [N-1:0] m,
                                        input logic l1, input logic l2, input logic sin,
                                        input logic [N-1:0] rsp);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) begin
      logic en, pr;
      en = m[k] ? l2 : l1;
      pr = (k == 0) ? sin : cur[k-1];
      r[k] = en ? pr : rsp[k];
    end
    return r;
  endfunction

  task automatic run(input logic [N-1:0] ma, mb, input logic l1, l2,
                     input logic [N-1:0] pa, pb, rla, rlb, rca, rcb, na, nb,
                     input bit disturb);
    logic [N-1:0] ea, eb, ca, cb;
    @(negedge clk);
    start = 1; grp_map_a = ma; grp_map_b = mb; lvl_sen1 = l1; lvl_sen2 = l2;
    @(negedge clk);
    start = 0;
    if (disturb) begin grp_map_a = ~ma; grp_map_b = ~mb; end
    for (int i = 0; i < N; i++) begin
      if (i == 1) chk(sen1 && sen2, "R2 load enables", {sen1, sen2}, 2'b11);
      scan_in_a = pa[N-1-i]; scan_in_b = pb[N-1-i];
      @(negedge clk);
    end
    chk(chain_a == pa, "R2 load chain A", chain_a, pa);
    chk(chain_b == pb, "R2 load chain B", chain_b, pb);
    @(negedge clk);
    chk(chain_a == pa && chain_b == pb, "R3 prep hold", {chain_a, chain_b}, {pa, pb});
    chk(sen1 == l1 && sen2 == l2, "R3 launch levels", {sen1, sen2}, {l1, l2});
    if (disturb) begin lvl_sen1 = ~l1; lvl_sen2 = ~l2; start = 1; end
    scan_in_a = 1; scan_in_b = 0; resp_a = rla; resp_b = rlb;
    @(negedge clk);
    ea = step(pa, ma, l1, l2, 1'b1, rla);
    eb = step(pb, mb, l1, l2, 1'b0, rlb);
    chk(chain_a == ea, "R4 launch chain A", chain_a, ea);
    chk(chain_b == eb, "R4 launch chain B", chain_b, eb);
    chk(sen1 == l1 && sen2 == l2, "R5 levels static", {sen1, sen2}, {l1, l2});
    resp_a = rca; resp_b = rcb; start = 0;
    @(negedge clk);
    ca = step(ea, ma, l1, l2, 1'b1, rca);
    cb = step(eb, mb, l1, l2, 1'b0, rcb);
    chk(chain_a == ca && chain_b == cb, disturb ? "R8 capture after disturb" : "R4 capture",
        {chain_a, chain_b}, {ca, cb});
    for (int i = 0; i < N; i++) begin
      chk(scan_out_a == ca[N-1-i] && scan_out_b == cb[N-1-i], "R6 unload order",
          {scan_out_a, scan_out_b}, {ca[N-1-i], cb[N-1-i]});
      if (i == 2) chk(sen1 && sen2, "R6 unload enables", {sen1, sen2}, 2'b11);
      scan_in_a = na[N-1-i]; scan_in_b = nb[N-1-i];
      @(negedge clk);
    end
    chk(done && !busy, "R7 done pulse", {done, busy}, 2'b10);
    chk(chain_a == na && chain_b == nb, "R6 next pattern", {chain_a, chain_b}, {na, nb});
    @(negedge clk);
    chk(!done && !sen1 && !sen2, "R7 after done", {done, sen1, sen2}, 3'b000);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #12 chk(chain_a == 0 && chain_b == 0 && !sen1 && !sen2 && !busy && !done, "R1 reset state",
            {chain_a, chain_b, sen1, sen2, busy, done}, '0);
    rst_n = 1;
    run('0, '0, 0, 0, 5'b10110, 5'b01101, 5'b00111, 5'b11000, 5'b01010, 5'b10101, 5'b11100, 5'b00011, 0);
    run('1, '1, 1, 1, 5'b10011, 5'b01100, 5'b11111, 5'b00000, 5'b00000, 5'b11111, 5'b01010, 5'b10101, 0);
    run(5'b11010, 5'b00110, 0, 1, 5'b01011, 5'b11001, 5'b10100, 5'b01111, 5'b00110, 5'b10001, 5'b00001, 5'b10000, 0);
    run(5'b01101, 5'b10010, 1, 0, 5'b11110, 5'b00001, 5'b01001, 5'b10110, 5'b11011, 5'b00100, 5'b01110, 5'b10011, 1);
    for (int t = 0; t < 24; t++)
      run(N'($urandom), N'($urandom), 1'($urandom), 1'($urandom), N'($urandom), N'($urandom),
          N'($urandom), N'($urandom), N'($urandom), N'($urandom), N'($urandom), N'($urandom),
          (t % 3) == 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule